// File: doc/BRIEF.md
# DRAM Bank Size Totalizer

The block turns the programmed size code of each DRAM bank, plus the amount of memory actually fitted in that bank, into the usable system memory total. It also derives the two address-window enables a memory decoder needs. One window covers conventional memory from 0 to 640 KB. The other covers extended memory starting at 1 MB, and its length is reported in KB.

Each bank's 3-bit size code sits in one nibble of a packed configuration word. A bank counts only as much memory as both its code and its installed amount allow. The installed amounts come from a separate sizing step and are presented as KB counts. Results are held in registers and are recomputed only when a recalculate strobe is given. One cycle after the strobe, the new values appear together with a one-cycle done pulse.

Top module: `mem_size_totalizer`

## Requirements
- R1: While reset is asserted, and after it is released until the first recalculate, total_kb_o, low_win_en_o, high_win_en_o, high_win_kb_o and done_o are all zero.
- R2: A size code c maps to 0 KB for c = 0 and c = 1, and to 1024 << (c - 2) KB for c from 2 to 7. So code 7 is 32768 KB.
- R3: Bank 0's code is cfg_i[2:0], bank 1's is cfg_i[6:4], bank 2's is cfg_i[10:8] and bank 3's is cfg_i[14:12]. Bits 3, 7, 11 and 15 have no effect on any output.
- R4: Each bank contributes the smaller of its code size and its installed KB count, where bank i's count is inst_kb_i[16*i+15:16*i].
- R5: total_kb_o is the sum of the four bank contributions.
- R6: For a total above 1024 KB, low_win_en_o = 1, high_win_en_o = 1 and high_win_kb_o = total - 1024.
- R7: For a total of exactly 1024 KB, low_win_en_o = 1, high_win_en_o = 0 and high_win_kb_o = 0.
- R8: For a total below 1024 KB, low_win_en_o = 0, high_win_en_o = 0 and high_win_kb_o = 0.
- R9: All result outputs take the values computed from the inputs present at the clock edge where recalc_i is high. done_o is high for exactly the cycle after each such edge.
- R10: Changes on cfg_i and inst_kb_i while recalc_i is low leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recalc_i | input | 1 | Recalculate strobe |
| cfg_i | input | 16 | Packed bank size codes, one nibble per bank |
| inst_kb_i | input | 64 | Installed KB per bank, 16 bits each, bank 0 lowest |
| total_kb_o | output | 18 | Usable memory total in KB |
| low_win_en_o | output | 1 | Conventional window enable |
| high_win_en_o | output | 1 | Extended window enable |
| high_win_kb_o | output | 18 | Extended window length in KB |
| done_o | output | 1 | One-cycle pulse after a recalculation |

## Verification
A wrong cap or a wrong code decode in any bank shows up as a wrong total_kb_o. It appears in the cycle right after the recalculate strobe. The window fields move with it, often across the 1024 KB threshold, so the enables flip as well. A fault in the hold or strobe logic shows up as outputs or done_o changing in idle cycles. The reference model is compared against the outputs on every clock, so any of these faults is reported within one cycle of the edge that causes it.

// File: rtl/mts_pkg.sv
package mts_pkg;
   // KB size encoded by a bank size code; codes below 2 mean an empty bank
   function automatic int unsigned code_kb(input int unsigned code,
                                           input int unsigned base_kb);
      if (code < 2) return 0;
      return base_kb << (code - 2);
   endfunction
endpackage

// File: rtl/mts_bank_cap.sv
module mts_bank_cap #(
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned INST_W   = 16,
   parameter int unsigned TOT_W    = 18,
   parameter int unsigned BASE_KB  = 1024,
   parameter bit          USE_INST = 1'b1
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [INST_W-1:0] inst_kb_i,
   output logic [TOT_W-1:0]  cap_kb_o
);
   import mts_pkg::*;

   logic [TOT_W-1:0] code_size;
   logic [TOT_W-1:0] inst_size;

   always_comb begin
      code_size = TOT_W'(code_kb(int'(code_i), BASE_KB));
      inst_size = TOT_W'(inst_kb_i);
   end

   generate
      if (USE_INST) begin : g_capped
         assign cap_kb_o = (inst_size < code_size) ? inst_size : code_size;
      end else begin : g_code_only
         assign cap_kb_o = code_size;
      end
   endgenerate
endmodule

// File: rtl/mts_sum.sv
module mts_sum #(
   parameter int unsigned N_TERMS = 4,
   parameter int unsigned TOT_W   = 18
) (
   input  logic [N_TERMS*TOT_W-1:0] terms_i,
   output logic [TOT_W-1:0]         sum_o
);
   always_comb begin
      sum_o = '0;
      for (int k = 0; k < N_TERMS; k++) begin
         sum_o = sum_o + terms_i[k*TOT_W +: TOT_W];
      end
   end
endmodule

// File: rtl/mts_window.sv
module mts_window #(
   parameter int unsigned TOT_W    = 18,
   parameter int unsigned SPLIT_KB = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TOT_W-1:0] total_i,
   output logic [TOT_W-1:0] total_o,
   output logic             low_en_o,
   output logic             high_en_o,
   output logic [TOT_W-1:0] high_kb_o,
   output logic             done_o
);
   localparam logic [TOT_W-1:0] SPLIT = TOT_W'(SPLIT_KB);

   logic             above;
   logic             at_least;
   logic [TOT_W-1:0] excess;

   always_comb begin
      above    = total_i > SPLIT;
      at_least = total_i >= SPLIT;
      excess   = above ? (total_i - SPLIT) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_o   <= '0;
         low_en_o  <= 1'b0;
         high_en_o <= 1'b0;
         high_kb_o <= '0;
         done_o    <= 1'b0;
      end else begin
         done_o <= load_i;
         if (load_i) begin
            total_o   <= total_i;
            low_en_o  <= at_least;
            high_en_o <= above;
            high_kb_o <= excess;
         end
      end
   end

   p_done_after_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> done_o);
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !done_o);
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(total_o) && $stable(low_en_o) &&
                   $stable(high_en_o) && $stable(high_kb_o)));
   p_high_implies_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      high_en_o |-> low_en_o);
   p_high_len_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !high_en_o |-> (high_kb_o == '0));
   p_high_len_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      high_en_o |-> (high_kb_o < total_o));
endmodule

// File: rtl/mem_size_totalizer.sv
module mem_size_totalizer #(
   parameter int unsigned N_BANKS  = 4,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned NIBBLE_W = 4,
   parameter int unsigned INST_W   = 16,
   parameter int unsigned TOT_W    = 18,
   parameter int unsigned BASE_KB  = 1024,
   parameter int unsigned SPLIT_KB = 1024,
   parameter bit          USE_INST = 1'b1,
   localparam int unsigned CFG_W   = N_BANKS * NIBBLE_W,
   localparam int unsigned INSTV_W = N_BANKS * INST_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               recalc_i,
   input  logic [CFG_W-1:0]   cfg_i,
   input  logic [INSTV_W-1:0] inst_kb_i,
   output logic [TOT_W-1:0]   total_kb_o,
   output logic               low_win_en_o,
   output logic               high_win_en_o,
   output logic [TOT_W-1:0]   high_win_kb_o,
   output logic               done_o
);
   localparam longint unsigned MAX_BANK_KB = longint'(BASE_KB) << ((2 ** CODE_W) - 3);
   localparam longint unsigned MAX_TOT_KB  = MAX_BANK_KB * N_BANKS;
   localparam int unsigned     NEED_W      = $clog2(MAX_TOT_KB + 1);

   generate
      if (NIBBLE_W < CODE_W) begin : g_bad_nibble
         $error("NIBBLE_W must hold a full size code");
      end
      if (TOT_W < NEED_W) begin : g_bad_total
         $error("TOT_W too narrow for the largest total");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
   endgenerate

   logic [N_BANKS*TOT_W-1:0] caps;
   logic [TOT_W-1:0]         total_now;

   generate
      for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
         mts_bank_cap #(
            .CODE_W  (CODE_W),
            .INST_W  (INST_W),
            .TOT_W   (TOT_W),
            .BASE_KB (BASE_KB),
            .USE_INST(USE_INST)
         ) i_cap (
            .code_i   (cfg_i[b*NIBBLE_W +: CODE_W]),
            .inst_kb_i(inst_kb_i[b*INST_W +: INST_W]),
            .cap_kb_o (caps[b*TOT_W +: TOT_W])
         );

         if (USE_INST) begin : g_chk
            p_cap_within_inst_r4: assert property (@(posedge clk) disable iff (!rst_n)
               caps[b*TOT_W +: TOT_W] <= TOT_W'(inst_kb_i[b*INST_W +: INST_W]));
         end
      end
   endgenerate

   mts_sum #(
      .N_TERMS(N_BANKS),
      .TOT_W  (TOT_W)
   ) i_sum (
      .terms_i(caps),
      .sum_o  (total_now)
   );

   mts_window #(
      .TOT_W   (TOT_W),
      .SPLIT_KB(SPLIT_KB)
   ) i_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (recalc_i),
      .total_i  (total_now),
      .total_o  (total_kb_o),
      .low_en_o (low_win_en_o),
      .high_en_o(high_win_en_o),
      .high_kb_o(high_win_kb_o),
      .done_o   (done_o)
   );
endmodule

// File: tb/test_mem_size_totalizer.sv
`timescale 1ns/1ps
module test_mem_size_totalizer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        recalc = 1'b0;
   logic [15:0] cfg = '0;
   logic [63:0] inst = '0;
   logic [17:0] total_kb, high_kb;
   logic        low_en, high_en, done;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    finished = 1'b0;

   // reference state
   int m_total = 0, m_hkb = 0;
   bit m_low = 0, m_high = 0, m_done = 0;

   always #4 clk = ~clk;

   mem_size_totalizer i_mem_size_totalizer (
      .clk(clk), .rst_n(rst_n), .recalc_i(recalc), .cfg_i(cfg),
      .inst_kb_i(inst), .total_kb_o(total_kb), .low_win_en_o(low_en),
      .high_win_en_o(high_en), .high_win_kb_o(high_kb), .done_o(done)
   );

   function automatic int size_of(int c);
      int v;
      if (c <= 1) return 0;
      v = 1024;
      for (int k = 2; k < c; k++) v = v * 2;
      return v;
   endfunction

   function automatic int ref_total(logic [15:0] c, logic [63:0] in);
      int s = 0;
      for (int b = 0; b < 4; b++) begin
         int code_sz, fit;
         code_sz = size_of(int'(c[b*4 +: 3]));
         fit     = int'(in[b*16 +: 16]);
         s += (fit < code_sz) ? fit : code_sz;
      end
      return s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_total = 0; m_hkb = 0; m_low = 0; m_high = 0; m_done = 0;
      end else begin
         m_done = recalc;
         if (recalc) begin
            m_total = ref_total(cfg, inst);
            m_low   = m_total >= 1024;
            m_high  = m_total > 1024;
            m_hkb   = m_high ? m_total - 1024 : 0;
         end
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         string t;
         t = rst_n ? tag : "R1";
         checks++;
         if (int'(total_kb) != m_total || low_en != m_low || high_en != m_high ||
             int'(high_kb) != m_hkb) begin
            errors++;
            $display("FAIL %s: total=%0d exp %0d low=%b exp %b high=%b exp %b hkb=%0d exp %0d",
                     t, total_kb, m_total, low_en, m_low, high_en, m_high, high_kb, m_hkb);
         end
         checks++;
         if (done != m_done) begin
            errors++;
            $display("FAIL %s R9: done=%b exp %b", t, done, m_done);
         end
      end
   end

   function automatic logic [63:0] pack(int a, int b, int c, int d);
      return {16'(d), 16'(c), 16'(b), 16'(a)};
   endfunction

   // one recalculation, then two idle cycles with scrambled inputs (R10)
   task automatic run(string t, logic [15:0] c, logic [63:0] in);
      @(negedge clk);
      tag = t; cfg = c; inst = in; recalc = 1'b1;
      @(negedge clk);
      recalc = 1'b0; tag = "R10";
      cfg = ~c; inst = ~in;
      @(negedge clk);
      cfg = 16'h5a5a; inst = 64'h0123_4567_89ab_cdef;
      @(negedge clk);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      @(posedge clk); #2 rst_n = 1'b1;
      tag = "R1";
      repeat (2) @(negedge clk);
      // R2: each code alone in bank 0 with ample installed memory
      for (int c = 0; c < 8; c++) run("R2", 16'(c), pack(32768, 0, 0, 0));
      // R3: each bank position, spare bits set
      run("R3", 16'h8888 | 16'h0050, pack(0, 32768, 0, 0));
      run("R3", 16'h8888 | 16'h0600, pack(0, 0, 32768, 0));
      run("R3", 16'h8888 | 16'h7000, pack(0, 0, 0, 32768));
      run("R3", 16'hffff, pack(65535, 65535, 65535, 65535));
      // R4: installed smaller than code, and code smaller than installed
      run("R4", 16'h0007, pack(3000, 0, 0, 0));
      run("R4", 16'h0003, pack(60000, 0, 0, 0));
      // R5: mixed banks summing
      run("R5", 16'h4532, pack(900, 4096, 8192, 2048));
      // R6 / R7 / R8 around the split
      run("R6", 16'h0022, pack(1024, 1, 0, 0));
      run("R7", 16'h0022, pack(512, 512, 0, 0));
      run("R8", 16'h0022, pack(640, 0, 0, 0));
      run("R8", 16'h0000, pack(65535, 65535, 65535, 65535));
      run("R6", 16'h7777, pack(32768, 32768, 32768, 32768));
      // R9: back-to-back strobes
      @(negedge clk); tag = "R9"; cfg = 16'h0004; inst = pack(5000, 0, 0, 0); recalc = 1'b1;
      @(negedge clk); cfg = 16'h0005; inst = pack(5000, 0, 0, 0);
      @(negedge clk); recalc = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset mid-run clears results
      @(posedge clk); #2 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      @(posedge clk); #2 rst_n = 1'b1;
      tag = "R1";
      repeat (2) @(negedge clk);
      run("R6", 16'h0065, pack(7000, 10000, 0, 0));
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule